// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page mappings and translates a lookup address within the same cycle. Every stored entry can hold any page. On each lookup the upper address bits are compared against all entries at once. The matching entry's physical frame is then selected and joined with the untranslated page offset. The requested access (read or write) is checked against the entry's permission bits. Any hit that is not allowed is reported as a fault and yields no usable address.

Software or a walker outside the block loads mappings through a fill port. A fill goes to the lowest-numbered empty slot. When every slot is occupied, a rotating victim pointer chooses the slot instead. A flush input empties the whole buffer in one clock. Each entry also records whether it has been used and whether it has been written through. These two bits are shown on every hit so that the caller can see them.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no entry is valid, so every lookup misses. Before any fill, hit, fault, paValid, pa, hitUsed and hitDirty all read 0.
- R2: A lookup with lookupValid=1 hits when va[42:13] equals the tag of a valid entry. The result appears in the same cycle as hit=1, paValid=1 and pa = {frame[20:0], va[12:0]}.
- R3: A lookup whose tag matches no valid entry gives hit=0, fault=0, paValid=0 and pa=0.
- R4: A read (lookupWrite=0) is permitted only when the entry's read bit is set. A write (lookupWrite=1) is permitted only when its write bit is set. A hit that is not permitted gives hit=1, fault=1, paValid=0 and pa=0.
- R5: On a hit, hitUsed and hitDirty show the entry's stored use and dirty bits as they were before this access. A permitted hit sets the use bit from the next cycle on, and a permitted write also sets the dirty bit. A faulting hit changes neither bit. A fill clears both bits of the entry it writes.
- R6: When at least one entry is invalid, a fill writes the lowest-indexed invalid entry and leaves the victim pointer unchanged.
- R7: When every entry is valid, a fill writes the entry under the victim pointer. The pointer then advances by one and wraps after the last entry. It is 0 after reset and is not reset by flush.
- R8: Flush makes every entry invalid from the next cycle on. A fill in the same cycle as flush is discarded.
- R9: With lookupValid=0, all lookup outputs are 0 and no use or dirty bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup strobe |
| lookupWrite | input | 1 | 1 = write access, 0 = read access |
| lookupVa | input | 43 | Virtual address to translate |
| hit | output | 1 | A valid entry matches the tag |
| fault | output | 1 | Hit whose permission forbids the access |
| paValid | output | 1 | pa holds a usable translation |
| pa | output | 34 | Physical address, 0 unless paValid |
| hitUsed | output | 1 | Stored use bit of the matching entry |
| hitDirty | output | 1 | Stored dirty bit of the matching entry |
| fillValid | input | 1 | Write one mapping |
| fillTag | input | 30 | Virtual page tag to store |
| fillFrame | input | 21 | Physical frame to store |
| fillRead | input | 1 | Read permission for the new entry |
| fillWrite | input | 1 | Write permission for the new entry |
| flush | input | 1 | Invalidate all entries |

## Verification
The match-uniqueness assertion assumes that no tag is ever stored twice among the valid entries. Only the fill source can guarantee this, so the stimulus gives every fill a distinct tag and flushes before any tag is reused. The use and dirty assertions assume that a lookup and a fill do not target the same entry in one cycle. The bench never drives a lookup and a fill together. The flush and fill checks assume that fill fields are stable while fillValid is high, and the bench holds them for the whole strobe cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W    = 43;
  localparam int OFF_W   = 13;
  localparam int TAG_W   = VA_W - OFF_W;
  localparam int FRAME_W = 21;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int ENTRIES = 32;
  localparam int IDX_W   = $clog2(ENTRIES);

  typedef struct packed {
    logic             flushAll;
    logic             fillEn;
    logic [IDX_W-1:0] fillIdx;
    logic             touchEn;
    logic             markDirty;
    logic [IDX_W-1:0] touchIdx;
  } ctrl_strobe_t;
endpackage

// File: rtl/xlat_entries.sv
module xlat_entries
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  input  logic [TAG_W-1:0]   lookupTag,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic               fillRead,
  input  logic               fillWrite,
  output logic [ENTRIES-1:0] validVec,
  output logic               anyMatch,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [FRAME_W-1:0] hitFrame,
  output logic               hitRead,
  output logic               hitWrite,
  output logic               hitUsed,
  output logic               hitDirty
);
  logic [TAG_W-1:0]   tagArr   [ENTRIES];
  logic [FRAME_W-1:0] frameArr [ENTRIES];
  logic [ENTRIES-1:0] readVec, writeVec, useVec, dirtyVec, matchVec;

  // parallel tag compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign matchVec[g] = validVec[g] && (tagArr[g] == lookupTag);
  end

  assign anyMatch = |matchVec;

  // one-hot select of the matching entry
  always_comb begin
    hitIdx   = '0;
    hitFrame = '0;
    hitRead  = 1'b0;
    hitWrite = 1'b0;
    hitUsed  = 1'b0;
    hitDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitIdx   = hitIdx | IDX_W'(i);
        hitFrame = hitFrame | frameArr[i];
        hitRead  = hitRead | readVec[i];
        hitWrite = hitWrite | writeVec[i];
        hitUsed  = hitUsed | useVec[i];
        hitDirty = hitDirty | dirtyVec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushAll) begin
      validVec <= '0;
      useVec   <= '0;
      dirtyVec <= '0;
    end else begin
      if (strobe.touchEn && !(strobe.fillEn && strobe.fillIdx == strobe.touchIdx)) begin
        useVec[strobe.touchIdx] <= 1'b1;
        if (strobe.markDirty) dirtyVec[strobe.touchIdx] <= 1'b1;
      end
      if (strobe.fillEn) begin
        validVec[strobe.fillIdx] <= 1'b1;
        useVec[strobe.fillIdx]   <= 1'b0;
        dirtyVec[strobe.fillIdx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillEn) begin
      tagArr[strobe.fillIdx]   <= fillTag;
      frameArr[strobe.fillIdx] <= fillFrame;
      readVec[strobe.fillIdx]  <= fillRead;
      writeVec[strobe.fillIdx] <= fillWrite;
    end
  end

  assert_onehot_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
  assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> validVec[$past(strobe.fillIdx)]);
  assert_touch_sets_use_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.touchEn && !strobe.fillEn && !strobe.flushAll) |=> useVec[$past(strobe.touchIdx)]);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (validVec == '0));
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic               fillValid,
  input  logic               flush,
  input  logic [ENTRIES-1:0] validVec,
  input  logic               anyMatch,
  input  logic [IDX_W-1:0]   hitIdx,
  input  logic               hitRead,
  input  logic               hitWrite,
  output ctrl_strobe_t       strobe,
  output logic               hit,
  output logic               fault,
  output logic               paValid
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             freeFound;
  logic             allowed;

  // lowest-indexed invalid entry
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  assign hit     = lookupValid && anyMatch;
  assign allowed = lookupWrite ? hitWrite : hitRead;
  assign fault   = hit && !allowed;
  assign paValid = hit && allowed;

  always_comb begin
    strobe.flushAll  = flush;
    strobe.fillEn    = fillValid && !flush;
    strobe.fillIdx   = freeFound ? freeIdx : rrPtr;
    strobe.touchEn   = paValid;
    strobe.markDirty = paValid && lookupWrite;
    strobe.touchIdx  = hitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.fillEn && !freeFound) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  assert_ptr_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !flush && validVec != '1) |=> $stable(rrPtr));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic [VA_W-1:0]    lookupVa,
  output logic               hit,
  output logic               fault,
  output logic               paValid,
  output logic [PA_W-1:0]    pa,
  output logic               hitUsed,
  output logic               hitDirty,
  input  logic               fillValid,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic               fillRead,
  input  logic               fillWrite,
  input  logic               flush
);
  ctrl_strobe_t       strobe;
  logic [ENTRIES-1:0] validVec;
  logic               anyMatch, hitRead, hitWrite, rawUsed, rawDirty;
  logic [IDX_W-1:0]   hitIdx;
  logic [FRAME_W-1:0] hitFrame;

  xlat_entries u_entries (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookupTag(lookupVa[VA_W-1:OFF_W]),
    .fillTag(fillTag), .fillFrame(fillFrame),
    .fillRead(fillRead), .fillWrite(fillWrite),
    .validVec(validVec), .anyMatch(anyMatch), .hitIdx(hitIdx),
    .hitFrame(hitFrame), .hitRead(hitRead), .hitWrite(hitWrite),
    .hitUsed(rawUsed), .hitDirty(rawDirty)
  );

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .fillValid(fillValid), .flush(flush), .validVec(validVec),
    .anyMatch(anyMatch), .hitIdx(hitIdx), .hitRead(hitRead), .hitWrite(hitWrite),
    .strobe(strobe), .hit(hit), .fault(fault), .paValid(paValid)
  );

  assign pa       = paValid ? {hitFrame, lookupVa[OFF_W-1:0]} : '0;
  assign hitUsed  = hit && rawUsed;
  assign hitDirty = hit && rawDirty;

  assert_fault_blocks_pa_R4: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!paValid && pa == '0));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> (!hit && !fault && !paValid));
  assert_offset_passes_R2: assert property (@(posedge clk) disable iff (!rstN)
    paValid |-> (pa[OFF_W-1:0] == lookupVa[OFF_W-1:0]));
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0, lookupWrite = 1'b0;
  logic [42:0] lookupVa = '0;
  logic        hit, fault, paValid, hitUsed, hitDirty;
  logic [33:0] pa;
  logic        fillValid = 1'b0, fillRead = 1'b0, fillWrite = 1'b0, flush = 1'b0;
  logic [29:0] fillTag = '0;
  logic [20:0] fillFrame = '0;
  int total = 0, bad = 0;
  logic sHit, sFault, sPaValid, sUsed, sDirty;
  logic [33:0] sPa;

  always #10 clk = ~clk;

  xlat_buffer u_xlat_buffer (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupVa(lookupVa), .hit(hit), .fault(fault), .paValid(paValid), .pa(pa),
    .hitUsed(hitUsed), .hitDirty(hitDirty), .fillValid(fillValid), .fillTag(fillTag),
    .fillFrame(fillFrame), .fillRead(fillRead), .fillWrite(fillWrite), .flush(flush)
  );

  function automatic logic [29:0] tagOf(int i);  return 30'h0001_2000 + 30'(i * 7); endfunction
  function automatic logic [20:0] frameOf(int i); return 21'h0_0400 + 21'(i * 3); endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic [29:0] t, input logic [20:0] f, input logic r, input logic w);
    @(negedge clk);
    fillValid = 1'b1; fillTag = t; fillFrame = f; fillRead = r; fillWrite = w;
    @(posedge clk); #1;
    fillValid = 1'b0;
  endtask

  task automatic doFlush(input bit withFill);
    @(negedge clk);
    flush = 1'b1;
    fillValid = withFill; fillTag = tagOf(99); fillFrame = frameOf(99); fillRead = 1'b1; fillWrite = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0; fillValid = 1'b0;
  endtask

  task automatic doLookup(input logic [42:0] va, input logic wr, input logic strobeOn);
    @(negedge clk);
    lookupValid = strobeOn; lookupWrite = wr; lookupVa = va;
    #5;
    sHit = hit; sFault = fault; sPaValid = paValid; sPa = pa; sUsed = hitUsed; sDirty = hitDirty;
    @(posedge clk); #1;
    lookupValid = 1'b0;
  endtask

  task automatic testReset;
    doLookup({tagOf(0), 13'h0}, 1'b0, 1'b1);
    check(!sHit && !sFault && !sPaValid && sPa == 0 && !sUsed && !sDirty, "R1 reset miss",
          {sHit, sFault, sPaValid, sPa}, 0);
  endtask

  task automatic testReadHit;
    doFill(tagOf(0), frameOf(0), 1'b1, 1'b0);
    doLookup({tagOf(0), 13'h1abc}, 1'b0, 1'b1);
    check(sHit && sPaValid && !sFault && sPa == {frameOf(0), 13'h1abc}, "R2 read hit pa",
          sPa, {frameOf(0), 13'h1abc});
    doLookup({tagOf(0), 13'h0007}, 1'b0, 1'b1);
    check(sPa == {frameOf(0), 13'h0007}, "R2 offset passthrough", sPa, {frameOf(0), 13'h0007});
  endtask

  task automatic testMiss;
    doLookup({tagOf(0) ^ 30'h1, 13'h55}, 1'b0, 1'b1);
    check(!sHit && !sFault && !sPaValid && sPa == 0, "R3 miss", {sHit, sPa}, 0);
  endtask

  task automatic testPerm;
    doLookup({tagOf(0), 13'h10}, 1'b1, 1'b1);
    check(sHit && sFault && !sPaValid && sPa == 0, "R4 write to read-only faults",
          {sHit, sFault, sPaValid, sPa}, {1'b1, 1'b1, 1'b0, 34'h0});
    doFill(tagOf(1), frameOf(1), 1'b0, 1'b1);
    doLookup({tagOf(1), 13'h20}, 1'b0, 1'b1);
    check(sHit && sFault && !sPaValid && sPa == 0, "R4 read of write-only faults",
          {sFault, sPaValid}, 2'b10);
    doLookup({tagOf(1), 13'h20}, 1'b1, 1'b1);
    check(!sFault && sPaValid && sPa == {frameOf(1), 13'h20}, "R4 permitted write",
          sPa, {frameOf(1), 13'h20});
  endtask

  task automatic testUseDirty;
    doFill(tagOf(2), frameOf(2), 1'b1, 1'b1);
    doLookup({tagOf(2), 13'h0}, 1'b0, 1'b0);
    check(!sHit && !sPaValid && sPa == 0, "R9 idle outputs zero", {sHit, sPa}, 0);
    doLookup({tagOf(2), 13'h0}, 1'b0, 1'b1);
    check(!sUsed && !sDirty, "R9 idle lookup left bits", {sUsed, sDirty}, 2'b00);
    doLookup({tagOf(2), 13'h0}, 1'b0, 1'b1);
    check(sUsed && !sDirty, "R5 read sets use only", {sUsed, sDirty}, 2'b10);
    doLookup({tagOf(2), 13'h0}, 1'b1, 1'b1);
    doLookup({tagOf(2), 13'h0}, 1'b0, 1'b1);
    check(sUsed && sDirty, "R5 write sets dirty", {sUsed, sDirty}, 2'b11);
    doLookup({tagOf(0), 13'h0}, 1'b1, 1'b1);
    doLookup({tagOf(0), 13'h0}, 1'b0, 1'b1);
    check(!sDirty && sUsed, "R5 faulting write leaves dirty clear", {sUsed, sDirty}, 2'b10);
  endtask

  task automatic testFlushAndReplace;
    doFlush(1'b1);
    doLookup({tagOf(99), 13'h0}, 1'b0, 1'b1);
    check(!sHit, "R8 fill with flush dropped", sHit, 0);
    doLookup({tagOf(2), 13'h0}, 1'b0, 1'b1);
    check(!sHit, "R8 flush invalidates", sHit, 0);
    for (int i = 0; i < 32; i++) doFill(tagOf(i), frameOf(i), 1'b1, 1'b1);
    begin
      int hits = 0;
      for (int i = 0; i < 32; i++) begin
        doLookup({tagOf(i), 13'h0}, 1'b0, 1'b1);
        if (sHit && sPa == {frameOf(i), 13'h0}) hits++;
      end
      check(hits == 32, "R6 fills use free slots", hits, 32);
    end
    doFill(tagOf(40), frameOf(40), 1'b1, 1'b1);
    doLookup({tagOf(0), 13'h0}, 1'b0, 1'b1);
    check(!sHit, "R7 pointer 0 evicts entry 0", sHit, 0);
    doLookup({tagOf(40), 13'h3}, 1'b0, 1'b1);
    check(sHit && sPa == {frameOf(40), 13'h3}, "R7 new mapping hits", sPa, {frameOf(40), 13'h3});
    doFill(tagOf(41), frameOf(41), 1'b1, 1'b1);
    doLookup({tagOf(1), 13'h0}, 1'b0, 1'b1);
    check(!sHit, "R7 pointer advanced to 1", sHit, 0);
    doLookup({tagOf(2), 13'h0}, 1'b0, 1'b1);
    check(sHit, "R7 entry 2 kept", sHit, 1);
    // pointer now 2; refill from empty must not move it
    doFlush(1'b0);
    for (int i = 0; i < 32; i++) doFill(tagOf(i + 50), frameOf(i), 1'b1, 1'b1);
    doFill(tagOf(90), frameOf(90), 1'b1, 1'b1);
    doLookup({tagOf(52), 13'h0}, 1'b0, 1'b1);
    check(!sHit, "R6 free fills kept pointer at 2", sHit, 0);
    doLookup({tagOf(50), 13'h0}, 1'b0, 1'b1);
    check(sHit, "R7 entry 0 survives", sHit, 1);
    // wrap: advance pointer from 3 to 31 then one more
    for (int i = 0; i < 29; i++) doFill(tagOf(100 + i), frameOf(i), 1'b1, 1'b1);
    doFill(tagOf(200), frameOf(5), 1'b1, 1'b1);
    doLookup({tagOf(50), 13'h0}, 1'b0, 1'b1);
    check(!sHit, "R7 pointer wraps to 0", sHit, 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testReadHit();
    testMiss();
    testPerm();
    testUseDirty();
    testFlushAndReplace();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule